// File: doc/BRIEF.md
# Switch-Programmed Accumulator Computer

This block is a minimal 8-bit accumulator machine with a 16-word by 8-bit memory. All of its registers sit around one shared 8-bit bus: the program counter, the memory address register with its input selector, the instruction register, the accumulator, the B operand register, the adder/subtractor and the output register. A six-state one-hot ring controller steps through each instruction.

The machine has two modes. In program mode (`run_mode` low), the address register follows the address switches, and a level write strobe stores the data switches into memory at that address. In run mode (`run_mode` high), the machine fetches and executes instructions starting at address 0 once `clr` is released. It stops for good when a halt instruction is decoded. `step_mode` chooses between advancing on every clock and advancing once per rising edge of `step_pulse`. Both cases use one clock domain, so no clock is gated.

Each instruction word carries the opcode in bits 7:4 and the operand address in bits 3:0.

Top module: `tac_core`

## Requirements
- R1: The memory holds 16 words of 8 bits. In program mode, a high `prog_we` at a rising clock edge stores `prog_data` at address `prog_addr`. With `prog_we` low, the memory is only read.
- R2: In program mode, the address register loads `prog_addr` on every clock. In run mode, it loads only from the bus, during T1 (program counter) and T4 (operand field, bits 3:0).
- R3: In run mode, `prog_we` has no effect on memory.
- R4: While `clr` is high, the program counter is 0, the ring is in T1 (one-hot bit 0), the instruction register is 0 and `halted` is 0. After `clr` falls in run mode, execution starts at address 0.
- R5: Opcode 4'hF (halt) sets `halted` in T4. From then on, nothing in the machine changes until `clr` is raised.
- R6: Every instruction takes exactly six enabled clocks, T1 to T6. Only one ring state is active at a time. T1 loads the address register from the program counter, T2 increments the program counter, and T3 loads the instruction register from memory.
- R7: Opcode 4'hE copies the accumulator into `out_val` in T4. `out_val` holds that value until the next such copy.
- R8: Opcode 4'h0 loads the accumulator from memory[operand]. Opcode 4'h1 adds memory[operand] to the accumulator and opcode 4'h2 subtracts it. Both results are modulo 256, and carry and overflow are discarded.
- R9: When `step_mode` is high, the machine advances by exactly one state per rising edge of `step_pulse` and holds still between edges. When `step_mode` is low, it advances on every clock.
- R10: The 4-bit program counter wraps from 15 to 0.
- R11: Any opcode other than 4'h0, 4'h1, 4'h2, 4'hE and 4'hF does nothing during its six states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high; low starts execution |
| run_mode | input | 1 | 1 = run, 0 = program (switch loading) |
| step_mode | input | 1 | 1 = advance on `step_pulse` rising edges, 0 = free running |
| step_pulse | input | 1 | Single-step pulse |
| prog_addr | input | 4 | Address switches |
| prog_data | input | 8 | Data switches |
| prog_we | input | 1 | Memory write strobe, program mode only |
| out_val | output | 8 | Output register |
| halted | output | 1 | High once a halt instruction has been executed |

## Verification
The hardest behaviour to reach from the ports is the program counter wrap. It only shows once a program has run through all sixteen words and comes back to address 0. The bench fills memory with unused opcodes that act as no-ops and puts an add at address 0 and an output instruction at address 14. It then expects the same add to take effect on a second pass, which the output values must show. The exact cycle count to halt checks the six-state timing. A write strobe applied in run mode before the first load shows that it was ignored, because the first output value depends on the word it targets.

// File: rtl/tac_pkg.sv
package tac_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int OP_W    = DATA_W - ADDR_W;
    localparam int N_STATE = 6;

    // ring state indices
    localparam int ST_T1 = 0;
    localparam int ST_T2 = 1;
    localparam int ST_T3 = 2;
    localparam int ST_T4 = 3;
    localparam int ST_T5 = 4;
    localparam int ST_T6 = 5;

    localparam logic [OP_W-1:0] OP_LDA = 4'h0;
    localparam logic [OP_W-1:0] OP_ADD = 4'h1;
    localparam logic [OP_W-1:0] OP_SUB = 4'h2;
    localparam logic [OP_W-1:0] OP_OUT = 4'hE;
    localparam logic [OP_W-1:0] OP_HLT = 4'hF;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_PC,
        SRC_MEM,
        SRC_IR,
        SRC_ACC,
        SRC_ALU
    } bus_src_e;

    typedef struct packed {
        bus_src_e src;
        logic     ld_mar;
        logic     ld_ir;
        logic     ld_acc;
        logic     ld_b;
        logic     ld_out;
        logic     inc_pc;
        logic     halt;
        logic     sub;
    } ctrl_t;

    function automatic logic [OP_W-1:0] opcode_of(input logic [DATA_W-1:0] w);
        return w[DATA_W-1 -: OP_W];
    endfunction

    function automatic logic [ADDR_W-1:0] operand_of(input logic [DATA_W-1:0] w);
        return w[ADDR_W-1:0];
    endfunction

endpackage

// File: rtl/tac_ring.sv
module tac_ring #(
    parameter int N = tac_pkg::N_STATE
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    output logic [N-1:0] ring
);
    localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (clr)
            ring <= FIRST;
        else if (en)
            ring <= {ring[N-2:0], ring[N-1]};
    end
endmodule

// File: rtl/tac_decode.sv
module tac_decode
    import tac_pkg::*;
(
    input  logic [N_STATE-1:0] ring,
    input  logic [OP_W-1:0]    op,
    output ctrl_t              ctrl
);
    always_comb begin
        ctrl     = '0;
        ctrl.src = SRC_NONE;
        if (ring[ST_T1]) begin
            ctrl.src    = SRC_PC;
            ctrl.ld_mar = 1'b1;
        end
        if (ring[ST_T2]) begin
            ctrl.inc_pc = 1'b1;
        end
        if (ring[ST_T3]) begin
            ctrl.src   = SRC_MEM;
            ctrl.ld_ir = 1'b1;
        end
        if (ring[ST_T4]) begin
            case (op)
                OP_LDA, OP_ADD, OP_SUB: begin
                    ctrl.src    = SRC_IR;
                    ctrl.ld_mar = 1'b1;
                end
                OP_OUT: begin
                    ctrl.src    = SRC_ACC;
                    ctrl.ld_out = 1'b1;
                end
                OP_HLT:  ctrl.halt = 1'b1;
                default: ;
            endcase
        end
        if (ring[ST_T5]) begin
            case (op)
                OP_LDA: begin
                    ctrl.src    = SRC_MEM;
                    ctrl.ld_acc = 1'b1;
                end
                OP_ADD, OP_SUB: begin
                    ctrl.src  = SRC_MEM;
                    ctrl.ld_b = 1'b1;
                end
                default: ;
            endcase
        end
        if (ring[ST_T6]) begin
            case (op)
                OP_ADD: begin
                    ctrl.src    = SRC_ALU;
                    ctrl.ld_acc = 1'b1;
                end
                OP_SUB: begin
                    ctrl.src    = SRC_ALU;
                    ctrl.ld_acc = 1'b1;
                    ctrl.sub    = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tac_alu.sv
module tac_alu #(
    parameter int W = tac_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    // two's complement: a - b = a + ~b + 1, carry out dropped
    logic [W-1:0] b_eff;
    always_comb begin
        b_eff = sub ? ~b : b;
        y     = a + b_eff + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/tac_mem.sv
module tac_mem #(
    parameter int DW = tac_pkg::DATA_W,
    parameter int AW = tac_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/tac_core.sv
module tac_core
    import tac_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              run_mode,
    input  logic              step_mode,
    input  logic              step_pulse,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              prog_we,
    output logic [DATA_W-1:0] out_val,
    output logic              halted
);
    logic [ADDR_W-1:0]  pc_q;
    logic [ADDR_W-1:0]  mar_q;
    logic [DATA_W-1:0]  ir_q;
    logic [DATA_W-1:0]  acc_q;
    logic [DATA_W-1:0]  b_q;
    logic [DATA_W-1:0]  out_q;
    logic               halt_q;
    logic               step_q;
    logic [N_STATE-1:0] ring_q;
    logic [DATA_W-1:0]  mem_rd;
    logic [DATA_W-1:0]  alu_y;
    logic [DATA_W-1:0]  bus;
    logic               step_rise;
    logic               en;
    ctrl_t              ctrl;

    // single-step edge detect, same clock domain
    always_ff @(posedge clk) step_q <= step_pulse;

    assign step_rise = step_pulse & ~step_q;
    assign en        = run_mode & ~clr & ~halt_q & (step_mode ? step_rise : 1'b1);

    tac_ring #(.N(N_STATE)) u_ring (
        .clk  (clk),
        .clr  (clr),
        .en   (en),
        .ring (ring_q)
    );

    tac_decode u_dec (
        .ring (ring_q),
        .op   (opcode_of(ir_q)),
        .ctrl (ctrl)
    );

    tac_alu #(.W(DATA_W)) u_alu (
        .a   (acc_q),
        .b   (b_q),
        .sub (ctrl.sub),
        .y   (alu_y)
    );

    tac_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (prog_we & ~run_mode),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (mar_q),
        .rdata (mem_rd)
    );

    // shared bus
    always_comb begin
        case (ctrl.src)
            SRC_PC:  bus = {{(DATA_W-ADDR_W){1'b0}}, pc_q};
            SRC_MEM: bus = mem_rd;
            SRC_IR:  bus = {{(DATA_W-ADDR_W){1'b0}}, operand_of(ir_q)};
            SRC_ACC: bus = acc_q;
            SRC_ALU: bus = alu_y;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr)
            pc_q <= '0;
        else if (en && ctrl.inc_pc)
            pc_q <= pc_q + 1'b1;
    end

    // address register input selector: switches or bus
    always_ff @(posedge clk) begin
        if (!run_mode)
            mar_q <= prog_addr;
        else if (en && ctrl.ld_mar)
            mar_q <= bus[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (clr)
            ir_q <= '0;
        else if (en && ctrl.ld_ir)
            ir_q <= bus;
    end

    always_ff @(posedge clk) begin
        if (en && ctrl.ld_acc) acc_q <= bus;
        if (en && ctrl.ld_b)   b_q   <= bus;
        if (en && ctrl.ld_out) out_q <= bus;
    end

    always_ff @(posedge clk) begin
        if (clr)
            halt_q <= 1'b0;
        else if (en && ctrl.halt)
            halt_q <= 1'b1;
    end

    assign out_val = out_q;
    assign halted  = halt_q;
endmodule

// File: rtl/tac_chk.sv
module tac_chk (
    input logic       clk,
    input logic       clr,
    input logic       run_mode,
    input logic       en,
    input logic [3:0] prog_addr,
    input logic [5:0] ring,
    input logic [3:0] pc,
    input logic [7:0] ir,
    input logic [3:0] mar,
    input logic [7:0] acc,
    input logic [7:0] out_val,
    input logic       halted
);
    logic seen   = 1'b0;
    logic inited = 1'b0;

    always_ff @(posedge clk) begin
        seen   <= 1'b1;
        inited <= inited | clr;
    end

    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!seen)
        clr |=> (pc == 4'd0 && ring == 6'b000001 && ir == 8'd0 && !halted)); // R4

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!inited)
        $countones(ring) == 1); // R6

    AST_PROG_MAR: assert property (@(posedge clk) disable iff (!seen)
        !run_mode |=> mar == $past(prog_addr)); // R2

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!inited)
        (halted && !clr) |=> (halted && $stable(pc) && $stable(acc) && $stable(ring))); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!inited)
        !(en && ring[3] && ir[7:4] == 4'hE) |=> $stable(out_val)); // R7

    AST_STEP_IDLE: assert property (@(posedge clk) disable iff (!inited)
        (!en && !clr) |=> ($stable(ring) && $stable(pc))); // R9
endmodule

bind tac_core tac_chk u_chk (
    .clk       (clk),
    .clr       (clr),
    .run_mode  (run_mode),
    .en        (en),
    .prog_addr (prog_addr),
    .ring      (ring_q),
    .pc        (pc_q),
    .ir        (ir_q),
    .mar       (mar_q),
    .acc       (acc_q),
    .out_val   (out_val),
    .halted    (halted)
);

// File: tb/sim_tac_core.sv
module sim_tac_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       clr, run_mode, step_mode, step_pulse, prog_we;
    logic [3:0] prog_addr;
    logic [7:0] prog_data;
    logic [7:0] out_val;
    logic       halted;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] img [16];
    logic       mon_en = 1'b0;
    logic [7:0] prev_out;

    tac_core u0 (
        .clk(clk), .clr(clr), .run_mode(run_mode), .step_mode(step_mode),
        .step_pulse(step_pulse), .prog_addr(prog_addr), .prog_data(prog_data),
        .prog_we(prog_we), .out_val(out_val), .halted(halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // monitor: every change of the output register is scored
    always @(negedge clk) begin
        if (mon_en && out_val !== prev_out) begin
            prev_out = out_val;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected output change", out_val, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_val == e, t, "output value", out_val, e);
            end
        end
    end

    task automatic load_image();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            prog_addr = i[3:0];
            prog_data = img[i];
            prog_we   = 1'b1;
            @(negedge clk);
            prog_we   = 1'b0;
        end
    endtask

    task automatic pulse_step();
        @(negedge clk) step_pulse = 1'b1;
        repeat (3) @(negedge clk);
        step_pulse = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clr = 1'b1; run_mode = 1'b0; step_mode = 1'b0; step_pulse = 1'b0;
        prog_we = 1'b0; prog_addr = '0; prog_data = '0;
        repeat (3) @(negedge clk);
        check(halted == 1'b0, "R4", "halted under clear", halted, 0);

        // program A: load, add, out, sub, out, halt
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[0] = 8'h09; img[1] = 8'h1A; img[2] = 8'hE0; img[3] = 8'h2B;
        img[4] = 8'hE0; img[5] = 8'hF0;
        img[9] = 8'h10; img[10] = 8'h05; img[11] = 8'h20;
        load_image();
        prev_out = out_val;
        mon_en   = 1'b1;
        expect_out(8'h15, "R1 R2 R3 R8 add");
        expect_out(8'hF5, "R8 sub wrap");

        @(negedge clk) run_mode = 1'b1;
        // R3: strobe in run mode must not overwrite word 9
        prog_addr = 4'd9; prog_data = 8'h77; prog_we = 1'b1;
        repeat (2) @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk) clr = 1'b0;
        repeat (33) @(posedge clk);
        @(negedge clk);
        check(halted == 1'b0, "R6", "halted one clock before sixth T4", halted, 0);
        @(posedge clk);
        @(negedge clk);
        check(halted == 1'b1, "R5", "halted at sixth T4", halted, 1);
        repeat (20) @(negedge clk);
        check(halted == 1'b1, "R5", "halt persists", halted, 1);
        check(out_val == 8'hF5, "R7", "output held", out_val, 8'hF5);
        check(exp_q.size() == 0, "R7", "outputs pending", exp_q.size(), 0);

        // program B: manual stepping
        @(negedge clk) clr = 1'b1;
        run_mode = 1'b0;
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[0] = 8'h0E; img[1] = 8'h1F; img[2] = 8'hE0; img[3] = 8'hF0;
        img[14] = 8'hFF; img[15] = 8'h02;
        load_image();
        check(halted == 1'b0, "R4", "clear releases halt", halted, 0);
        expect_out(8'h01, "R8 R9 add wrap stepped");
        @(negedge clk);
        run_mode = 1'b1; step_mode = 1'b1;
        @(negedge clk) clr = 1'b0;
        repeat (12) @(negedge clk);
        check(out_val == 8'hF5, "R9", "no progress without pulses", out_val, 8'hF5);
        for (int k = 0; k < 21; k++) pulse_step();
        check(halted == 1'b0, "R9", "halted after 21 steps", halted, 0);
        pulse_step();
        check(halted == 1'b1, "R9", "halted after 22 steps", halted, 1);
        check(exp_q.size() == 0, "R9", "outputs pending", exp_q.size(), 0);

        // program C: no-op fill, counter wraps back to the add at word 0
        @(negedge clk) clr = 1'b1;
        run_mode = 1'b0; step_mode = 1'b0;
        img[0] = 8'h1D;
        for (int i = 1; i < 14; i++) img[i] = 8'h30;
        img[14] = 8'hE0; img[15] = 8'h40;
        load_image();
        expect_out(8'h31, "R11 no-ops then out");
        expect_out(8'h61, "R10 wrap re-executes word 0");
        @(negedge clk) run_mode = 1'b1;
        @(negedge clk) clr = 1'b0;
        repeat (200) @(negedge clk);
        check(halted == 1'b0, "R11", "unused opcodes never halt", halted, 0);
        check(exp_q.size() == 0, "R10", "outputs pending", exp_q.size(), 0);
        @(negedge clk) clr = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule